// File: doc/BRIEF.md
# Packed Integer Add/Subtract Unit

This block is a SIMD integer datapath that treats two wide operands as packed vectors of equal-width elements and adds or subtracts them lane by lane. Software-visible choices arrive with every operand pair: the operation (add or subtract), the element width (8, 16, 32 or 64 bits), and the overflow policy. The policy is one of three: wrap-around, clamping to the signed range, or clamping to the unsigned range. Clamping applies only to 8-bit and 16-bit elements. A saturating request at a wider element size falls back to wrap-around and raises an illegal-combination flag.

Each lane is independent. A single byte-sliced carry chain is cut at every element boundary chosen by the width select. A clamp stage then replaces any lane whose exact result falls outside the element range and marks that lane in a per-lane flag vector. The result, the flags and the illegal flag are registered once. They appear, together with `out_valid`, on the clock edge after `in_valid` was high.

Top module: `simd_addsub_unit`

## Requirements
- R1: With `arith_mode`=0 (wrap), every lane of `result` holds the low bits of the exact sum or difference at the element width, and the carry out of the lane is dropped. This holds for `elem_sz` 0/1/2/3 = 8/16/32/64-bit elements, which give 32/16/8/4 lanes. Lane i occupies bits [i*W +: W].
- R2: No carry or borrow passes from one element into the next. Each lane's value depends only on the same bit range of `opa` and `opb`.
- R3: With `op_sub`=1 every lane computes `opa` lane minus `opb` lane. With `op_sub`=0 it computes the sum.
- R4: With `arith_mode`=1 (signed saturate) at 8 or 16 bits, each lane is the exact two's-complement result clamped to [-2^(W-1), 2^(W-1)-1].
- R5: With `arith_mode`=2 (unsigned saturate) at 8 or 16 bits, each lane is clamped to [0, 2^W-1]. A subtraction that would go below zero yields 0, and an addition that would exceed the range yields all ones.
- R6: `sat_flags` bit i is 1 only when lane i was clamped, meaning the output differs from the exact result. Bits for lanes that do not exist at the chosen width are 0, and every bit is 0 in wrap mode.
- R7: `arith_mode` 1 or 2 with `elem_sz` 2 or 3, and `arith_mode`=3 at any width, produce the wrap result of R1 with `illegal_combo`=1 and all `sat_flags` 0. Every other combination gives `illegal_combo`=0.
- R8: Operands are taken on a rising edge where `in_valid`=1. `result`, `sat_flags`, `illegal_combo` and `out_valid`=1 appear after exactly that one edge. After an edge with `in_valid`=0, `out_valid` is 0 and the other outputs keep their values.
- R9: A synchronous active-high `rst` clears `out_valid`, `result`, `sat_flags` and `illegal_combo` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| elem_sz | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| arith_mode | input | 2 | 0 = wrap, 1 = signed saturate, 2 = unsigned saturate, 3 = reserved |
| opa | input | 256 | First operand vector |
| opb | input | 256 | Second operand vector |
| out_valid | output | 1 | Registered result is valid |
| result | output | 256 | Packed lane results |
| sat_flags | output | 32 | Per-lane clamp indicator, bit i = lane i |
| illegal_combo | output | 1 | Saturating mode requested where it is not supported |

## Verification
Every result of this block, including lane values, clamp flags, the illegal flag and `out_valid`, is due on the first rising edge after the cycle in which `in_valid` was high. The unit holds no other state. The bench changes inputs on falling edges and reads outputs on the next falling edge, so it samples exactly one register stage after the stimulus. It then lowers `in_valid` before the following rising edge and confirms at the next falling edge that `out_valid` drops while the data outputs hold.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    AM_WRAP = 2'd0,
    AM_SSAT = 2'd1,
    AM_USAT = 2'd2,
    AM_RSVD = 2'd3
  } amode_e;

  // True when byte index idx starts a new element at width code sz.
  function automatic logic lane_edge(input int unsigned idx, input logic [1:0] sz);
    return (idx & ((32'd1 << sz) - 32'd1)) == 32'd0;
  endfunction

  // Decides whether a lane leaves its range, and in which direction.
  // Returns {overflow, clamp_high}.
  //   sa, sb, ss : top bits of opa lane, opb lane and the wrapped result
  //   co         : carry out of the lane (no-borrow when subtracting)
  //   sub        : subtract
  //   sgn        : signed policy
  function automatic logic [1:0] clamp_kind(input logic sa, input logic sb,
                                            input logic ss, input logic co,
                                            input logic sub, input logic sgn);
    logic ovf;
    logic hi;
    if (sgn) begin
      ovf = sub ? ((sa != sb) && (ss != sa)) : ((sa == sb) && (ss != sa));
      hi  = ~sa;
    end else begin
      ovf = sub ? ~co : co;
      hi  = ~sub;
    end
    return {ovf, hi};
  endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                sub,
  input  logic [1:0]          sz,
  output logic [DATA_W-1:0]   sum,
  output logic [DATA_W/8-1:0] byte_cout
);
  localparam int NB = DATA_W / 8;

  // One 8-bit slice per byte; the carry into a slice is the subtract
  // injection at an element boundary, otherwise the previous slice's carry.
  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic       ci;
    logic       co;
    logic [8:0] t;
    if (k == 0) begin : g_first
      assign ci = sub;
    end else begin : g_rest
      assign ci = lane_edge(k, sz) ? sub : g_byte[k-1].co;
    end
    assign t = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8] ^ {8{sub}}} + {8'd0, ci};
    assign co = t[8];
    assign sum[8*k +: 8] = t[7:0];
    assign byte_cout[k] = co;
  end

endmodule

// File: rtl/simd_sat_stage.sv
module simd_sat_stage
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [DATA_W-1:0]   wsum,
  input  logic [DATA_W/8-1:0] byte_cout,
  input  logic                sub,
  input  logic [1:0]          sz,
  input  logic [1:0]          mode,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W/8-1:0] flags,
  output logic                illegal
);
  localparam int NB = DATA_W / 8;
  localparam int NH = NB / 2;

  logic              sgn;
  logic              sat_req;
  logic              sat_active;
  logic [DATA_W-1:0] r8;
  logic [DATA_W-1:0] r16;
  logic [NB-1:0]     lane_ovf8;
  logic [NH-1:0]     lane_ovf16;

  assign sgn        = (amode_e'(mode) == AM_SSAT);
  assign sat_req    = (amode_e'(mode) == AM_SSAT) || (amode_e'(mode) == AM_USAT);
  assign sat_active = sat_req && !sz[1];
  assign illegal    = (amode_e'(mode) != AM_WRAP) && !sat_active;

  // Byte lanes: clamp value is {sgn ^ high, {W-1{high}}}.
  for (genvar k = 0; k < NB; k++) begin : g_b8
    logic [1:0] kd;
    assign kd = clamp_kind(a[8*k+7], b[8*k+7], wsum[8*k+7], byte_cout[k], sub, sgn);
    assign r8[8*k +: 8] = kd[1] ? {sgn ^ kd[0], {7{kd[0]}}} : wsum[8*k +: 8];
    assign lane_ovf8[k] = kd[1];
  end

  // Halfword lanes: carry comes from the upper byte of the pair.
  for (genvar h = 0; h < NH; h++) begin : g_h16
    logic [1:0] kd;
    assign kd = clamp_kind(a[16*h+15], b[16*h+15], wsum[16*h+15],
                           byte_cout[2*h+1], sub, sgn);
    assign r16[16*h +: 16] = kd[1] ? {sgn ^ kd[0], {15{kd[0]}}} : wsum[16*h +: 16];
    assign lane_ovf16[h] = kd[1];
  end

  always_comb begin
    res   = wsum;
    flags = '0;
    if (sat_active) begin
      if (esz_e'(sz) == ESZ_8) begin
        res   = r8;
        flags = lane_ovf8;
      end else begin
        res   = r16;
        flags = {{(NB-NH){1'b0}}, lane_ovf16};
      end
    end
  end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit #(
  parameter int DATA_W = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                op_sub,
  input  logic [1:0]          elem_sz,
  input  logic [1:0]          arith_mode,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] sat_flags,
  output logic                illegal_combo
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] wrap_sum;
  logic [NB-1:0]     byte_cout;
  logic [DATA_W-1:0] lane_res;
  logic [NB-1:0]     lane_flags;
  logic              combo_bad;

  simd_seg_adder #(.DATA_W(DATA_W)) u_adder (
    .a         (opa),
    .b         (opb),
    .sub       (op_sub),
    .sz        (elem_sz),
    .sum       (wrap_sum),
    .byte_cout (byte_cout)
  );

  simd_sat_stage #(.DATA_W(DATA_W)) u_sat (
    .a         (opa),
    .b         (opb),
    .wsum      (wrap_sum),
    .byte_cout (byte_cout),
    .sub       (op_sub),
    .sz        (elem_sz),
    .mode      (arith_mode),
    .res       (lane_res),
    .flags     (lane_flags),
    .illegal   (combo_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      sat_flags     <= '0;
      illegal_combo <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= lane_res;
        sat_flags     <= lane_flags;
        illegal_combo <= combo_bad;
      end
    end
  end

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int NB = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          op_sub,
  input logic [1:0]    elem_sz,
  input logic [1:0]    arith_mode,
  input logic [15:0]   a_lo,
  input logic [15:0]   b_lo,
  input logic          out_valid,
  input logic [NB*8-1:0] result,
  input logic [NB-1:0] sat_flags,
  input logic          illegal_combo
);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags)));

  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_sz[1] && arith_mode != 2'd0) |=> (illegal_combo && sat_flags == '0));

  // R6
  wrap_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode == 2'd0) |=> (sat_flags == '0 && !illegal_combo));

  // R5
  usat_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode == 2'd2 && op_sub && elem_sz == 2'd0 && a_lo[7:0] < b_lo[7:0])
    |=> (result[7:0] == 8'd0 && sat_flags[0]));

  // R4
  ssat_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode == 2'd1 && !op_sub && elem_sz == 2'd1 &&
     a_lo == 16'h7fff && !b_lo[15] && b_lo != 16'd0)
    |=> (result[15:0] == 16'h7fff && sat_flags[0]));

endmodule

bind simd_addsub_unit simd_addsub_chk #(.NB(DATA_W/8)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .op_sub        (op_sub),
  .elem_sz       (elem_sz),
  .arith_mode    (arith_mode),
  .a_lo          (opa[15:0]),
  .b_lo          (opb[15:0]),
  .out_valid     (out_valid),
  .result        (result),
  .sat_flags     (sat_flags),
  .illegal_combo (illegal_combo)
);

// File: tb/tb_simd_addsub_unit.sv
module tb_simd_addsub_unit;

  typedef struct packed {
    logic         sub;
    logic [1:0]   sz;
    logic [1:0]   md;
    logic [255:0] a;
    logic [255:0] b;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, {32{8'hf0}},           {32{8'h25}}},
    '{1'b1, 2'd1, 2'd0, {16{16'h1234}},        {16{16'h4321}}},
    '{1'b0, 2'd2, 2'd0, {8{32'hffff_fff0}},    {8{32'h0000_0020}}},
    '{1'b1, 2'd3, 2'd0, {4{64'h0}},            {4{64'h1}}},
    '{1'b0, 2'd0, 2'd1, {32{8'h70}},           {16{8'h20, 8'h05}}},
    '{1'b1, 2'd0, 2'd1, {32{8'h90}},           {16{8'h7f, 8'h01}}},
    '{1'b0, 2'd1, 2'd1, {16{16'h8000}},        {8{16'hffff, 16'h0001}}},
    '{1'b1, 2'd1, 2'd1, {16{16'h7ff0}},        {8{16'h8000, 16'h0010}}},
    '{1'b0, 2'd0, 2'd2, {32{8'hc0}},           {16{8'h50, 8'h10}}},
    '{1'b1, 2'd0, 2'd2, {16{8'h10, 8'h80}},    {32{8'h20}}},
    '{1'b0, 2'd1, 2'd2, {16{16'hfff0}},        {8{16'h0020, 16'h0001}}},
    '{1'b1, 2'd1, 2'd2, {16{16'h0100}},        {8{16'h0200, 16'h0100}}},
    '{1'b0, 2'd2, 2'd1, {8{32'h7fff_ffff}},    {8{32'h0000_0001}}},
    '{1'b1, 2'd3, 2'd2, {4{64'h0}},            {4{64'h5}}},
    '{1'b0, 2'd0, 2'd3, {32{8'hff}},           {32{8'h02}}}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [1:0]   elem_sz = 2'd0;
  logic [1:0]   arith_mode = 2'd0;
  logic [255:0] opa = '0;
  logic [255:0] opb = '0;
  logic         out_valid;
  logic [255:0] result;
  logic [31:0]  sat_flags;
  logic         illegal_combo;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  simd_addsub_unit dut (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .op_sub        (op_sub),
    .elem_sz       (elem_sz),
    .arith_mode    (arith_mode),
    .opa           (opa),
    .opb           (opb),
    .out_valid     (out_valid),
    .result        (result),
    .sat_flags     (sat_flags),
    .illegal_combo (illegal_combo)
  );

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Lane-by-lane reference built from integer arithmetic.
  task automatic model(input vec_t v, output logic [255:0] r,
                       output logic [31:0] f, output logic ill);
    int w;
    int n;
    logic [63:0] mask;
    w    = 8 << v.sz;
    n    = 256 / w;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    ill  = (v.md != 2'd0) && (v.md == 2'd3 || v.sz >= 2'd2);
    r = '0;
    f = '0;
    for (int l = 0; l < n; l++) begin
      logic [63:0] ea;
      logic [63:0] eb;
      logic [63:0] lv;
      longint sa, sb, ex, lo, hi;
      ea = 64'(v.a >> (l * w)) & mask;
      eb = 64'(v.b >> (l * w)) & mask;
      if (v.md == 2'd0 || ill) begin
        lv = (v.sub ? ea - eb : ea + eb) & mask;
      end else if (v.md == 2'd1) begin
        sa = longint'(ea);
        sb = longint'(eb);
        if (ea[w-1]) sa = sa - (longint'(1) << w);
        if (eb[w-1]) sb = sb - (longint'(1) << w);
        ex = v.sub ? sa - sb : sa + sb;
        lo = -(longint'(1) << (w - 1));
        hi = (longint'(1) << (w - 1)) - 1;
        if (ex > hi) begin ex = hi; f[l] = 1'b1; end
        else if (ex < lo) begin ex = lo; f[l] = 1'b1; end
        lv = 64'(ex) & mask;
      end else begin
        ex = v.sub ? longint'(ea) - longint'(eb) : longint'(ea) + longint'(eb);
        if (ex < 0) begin ex = 0; f[l] = 1'b1; end
        else if (ex > longint'(mask)) begin ex = longint'(mask); f[l] = 1'b1; end
        lv = 64'(ex) & mask;
      end
      r = r | (256'(lv) << (l * w));
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.md == 2'd3 || (v.md != 2'd0 && v.sz >= 2'd2)) return "R7";
    if (v.md == 2'd1) return "R4";
    if (v.md == 2'd2) return "R5";
    return v.sub ? "R3" : "R1";
  endfunction

  logic [255:0] last_r;

  // Drive on a falling edge, check at the next falling edge (one register).
  task automatic run_vec(input string tag, input vec_t v);
    logic [255:0] er;
    logic [31:0]  ef;
    logic         ei;
    model(v, er, ef, ei);
    op_sub     = v.sub;
    elem_sz    = v.sz;
    arith_mode = v.md;
    opa        = v.a;
    opb        = v.b;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "result", result, er);
    chk("R6", "sat_flags", 256'(sat_flags), 256'(ef));
    chk(tag, "illegal_combo", 256'(illegal_combo), 256'(ei));
    chk("R8", "out_valid", 256'(out_valid), 256'd1);
    last_r = er;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_valid", 256'(out_valid), 256'd0);
    chk("R9", "result", result, 256'd0);
    chk("R9", "sat_flags", 256'(sat_flags), 256'd0);
    chk("R9", "illegal_combo", 256'(illegal_combo), 256'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(tag_of(VECS[i]), VECS[i]);

    // R2: same operands at two widths, carry must stop at the boundary
    run_vec("R2", '{1'b0, 2'd0, 2'd0, {16{16'h00ff}}, {16{16'h0001}}});
    chk("R2", "byte lanes", result, {16{16'h0000}});
    run_vec("R2", '{1'b0, 2'd1, 2'd0, {16{16'h00ff}}, {16{16'h0001}}});
    chk("R2", "half lanes", result, {16{16'h0100}});
    run_vec("R2", '{1'b1, 2'd2, 2'd0, {4{64'h0000_0001_0000_0000}}, {4{64'h0000_0000_0000_0001}}});
    chk("R2", "word borrow", result, {4{64'h0000_0001_ffff_ffff}});

    // R3: operand order of subtraction
    run_vec("R3", '{1'b1, 2'd0, 2'd0, {32{8'h05}}, {32{8'h03}}});
    chk("R3", "a-b", result, {32{8'h02}});
    run_vec("R3", '{1'b1, 2'd0, 2'd0, {32{8'h03}}, {32{8'h05}}});
    chk("R3", "b-a", result, {32{8'hfe}});

    // R6: exact boundary value is not a clamp
    run_vec("R6", '{1'b0, 2'd0, 2'd1, {32{8'h7e}}, {32{8'h01}}});
    chk("R6", "no flag at edge", 256'(sat_flags), 256'd0);
    run_vec("R6", '{1'b0, 2'd1, 2'd2, {16{16'hffff}}, {16{16'h0000}}});
    chk("R6", "no flag at max", 256'(sat_flags), 256'd0);

    // R8: idle cycle with changed inputs keeps outputs
    opa = {32{8'h55}};
    opb = {32{8'haa}};
    @(negedge clk);
    chk("R8", "idle out_valid", 256'(out_valid), 256'd0);
    chk("R8", "idle hold", result, last_r);

    // R9: reset during operation
    run_vec("R5", VECS[8]);
    rst = 1'b1;
    @(negedge clk);
    chk("R9", "rst out_valid", 256'(out_valid), 256'd0);
    chk("R9", "rst result", result, 256'd0);
    chk("R9", "rst sat_flags", 256'(sat_flags), 256'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule